// File: doc/BRIEF.md
# Serial SAR Converter Interface Sequencer

This block is the digital side of an eight-input, 16-bit successive-approximation converter that is reached over a four-wire serial port. A host drives a serial clock, an active-low select and a data line. The block looks for a control byte on that data line and decodes which inputs the front-end multiplexer should route to the converter. It then runs the acquire and hold phases and the sixteen bit decisions, and shifts the result back out MSB first on a data output. It also drives a busy flag. Both outputs carry an enable so that they can float. The analog comparator is replaced by a 16-bit sampled value input. The SAR logic compares its trial codes against that value.

Every serial event is taken from the fast system clock `clk`. The serial clock and select are sampled as data, and their edges are detected inside the block. A field in the control byte picks one of two timings. In external timing, the serial clock itself paces the bit decisions. In internal timing, a divider on `clk` paces the sixteen decisions, and the result is held until the host reads it.

Top module: `sar_serial_seq`

## Requirements
- R1: With `cs_n` low, `din` is sampled on rising `dclk` edges and `dout` changes only on falling `dclk` edges. `dout_oe` equals the inverse of `cs_n`, and `dclk` edges seen while `cs_n` is high are ignored.
- R2: Zeros on `din` are ignored until a one arrives. That one is the start bit. The next seven bits are taken in this order: A2, A1, A0, an unused bit, SGL, PD1, PD0.
- R3: With SGL = 1 (single-ended), `neg_com` = 1 and `pos_ch` = {A1, A0, A2}. Codes 000, 100, 001, 101, 010, 110, 011 and 111 therefore give channels 0 to 7. The multiplexer outputs change only on the rising edge that samples SGL.
- R4: With SGL = 0 (differential), `neg_com` = 0, `pos_ch` = {A1, A0, A2} and `neg_ch` = {A1, A0, ~A2}. Codes 000 to 011 give pairs 0/1, 2/3, 4/5 and 6/7 with the even channel positive. Codes 100 to 111 swap the polarity.
- R5: `track` goes high on the rising edge that samples SGL and goes low on the rising edge that samples PD0. At that same PD0 edge, `sample_val` is captured, and later changes to `sample_val` do not affect the result.
- R6: In external timing, `busy` is high from the first falling edge after PD0 until the next falling edge, with `dout` low during that period. The 16 result bits then appear MSB first on the next 16 falling edges, and any further falling edges drive 0.
- R7: The result is straight binary and equals the captured sample. Each decision, from bit 15 down to bit 0, keeps the trial bit set when the sample is greater than or equal to the trial code.
- R8: In internal timing, `busy` goes low at the PD0 edge and stays low for 16×`INT_DIV` `clk` cycles, one decision per `INT_DIV` cycles. It then returns high. `busy_oe` stays 1 whatever `cs_n` does.
- R9: After an internal conversion, each falling `dclk` edge with `cs_n` low drives the next result bit, MSB first. If `cs_n` is high when the conversion ends, `dout` floats until `cs_n` falls.
- R10: Each conversion uses the PD1:PD0 value written by the previous control byte. Value 10 selects internal timing, and 00, 01 and 11 select external timing. Reset behaves as if 11 had been written.
- R11: Raising `cs_n` before a control byte completes aborts that byte: `track` drops and no conversion starts. The start-bit search then begins again once `cs_n` is low.
- R12: After reset, `dout` = 0, `busy` = 0, `track` = 0, `pos_ch` = 0, `neg_ch` = 0 and `neg_com` = 1. With `cs_n` high, both enables are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; also paces internal conversions |
| rst_n | input | 1 | Asynchronous active-low reset |
| dclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Active-low select |
| din | input | 1 | Serial control data |
| sample_val | input | W | Digitised stand-in for the sampled analog level |
| dout | output | 1 | Serial result data |
| dout_oe | output | 1 | Output enable for `dout` |
| busy | output | 1 | Conversion status flag |
| busy_oe | output | 1 | Output enable for `busy` |
| pos_ch | output | 3 | Channel routed to the positive converter input |
| neg_ch | output | 3 | Channel routed to the negative input in differential mode |
| neg_com | output | 1 | Negative input tied to the common pin (single-ended) |
| track | output | 1 | 1 while acquiring, 0 while holding |

## Verification
The bench sweeps all sixteen combinations of channel code and input mode, so the interleaved single-ended order is told apart from the paired differential order and its swapped polarity. Sample values include the all-zero and all-one codes, the codes on either side of mid-scale, alternating patterns and a walking one. These show whether every SAR decision keeps or drops its trial bit and whether the bits leave in MSB-first order. Frames are also sent with leading zeros, back to back with the next start bit overlapping the LSB, and cut short by the select. These separate the start-bit search and the frame abort from the normal path. A sequence of power-down codes then covers the one-conversion delay of a timing change, and a readout started with the select low is compared against one started with it high.

// File: rtl/sar_serial_seq.sv
module sar_serial_seq #(
  parameter int W       = 16,
  parameter int INT_DIV = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         dclk,
  input  logic         cs_n,
  input  logic         din,
  input  logic [W-1:0] sample_val,
  output logic         dout,
  output logic         dout_oe,
  output logic         busy,
  output logic         busy_oe,
  output logic [2:0]   pos_ch,
  output logic [2:0]   neg_ch,
  output logic         neg_com,
  output logic         track
);
  localparam int CW = $clog2(W + 1);
  localparam int DW = (INT_DIV > 1) ? $clog2(INT_DIV) : 1;
  localparam logic [W-1:0] TOP = {1'b1, {(W-1){1'b0}}};

  typedef enum logic [2:0] {PH_IDLE, PH_EWAIT, PH_EBUSY, PH_ICONV, PH_SHIFT} phase_t;

  phase_t         phase;
  logic           dclk_q, cur_int, bz, dout_r;
  logic [2:0]     rx_cnt;
  logic [3:0]     rx_sr;
  logic [1:0]     pd_reg;
  logic [W-1:0]   samp, res;
  logic [CW-1:0]  nb;
  logic [DW-1:0]  divcnt;

  wire rise  = ~cs_n & dclk & ~dclk_q;
  wire fall  = ~cs_n & ~dclk & dclk_q;
  wire rx_en = rise & (phase != PH_ICONV);
  wire start = rx_en & (rx_cnt == 3'd7);

  wire [W-1:0] mask   = TOP >> nb;
  wire [W-1:0] trial  = res | mask;
  wire         cmp    = (samp >= trial);
  wire         rd_bit = cur_int ? |(res & mask) : cmp;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dclk_q  <= 1'b0;
      rx_cnt  <= '0;
      rx_sr   <= '0;
      pd_reg  <= 2'b11;
      cur_int <= 1'b0;
      track   <= 1'b0;
      pos_ch  <= '0;
      neg_ch  <= '0;
      neg_com <= 1'b1;
    end else begin
      dclk_q <= dclk;
      if (cs_n) begin
        rx_cnt <= '0;
        track  <= 1'b0;
      end else if (rx_en) begin
        if (rx_cnt == 3'd0) begin
          if (din) rx_cnt <= 3'd1;
        end else begin
          rx_sr  <= {rx_sr[2:0], din};
          rx_cnt <= rx_cnt + 3'd1;
          if (rx_cnt == 3'd5) begin
            pos_ch  <= {rx_sr[2], rx_sr[1], rx_sr[3]};
            neg_ch  <= {rx_sr[2], rx_sr[1], ~rx_sr[3]};
            neg_com <= din;
            track   <= 1'b1;
          end
          if (rx_cnt == 3'd7) begin
            rx_cnt  <= '0;
            track   <= 1'b0;
            pd_reg  <= {rx_sr[0], din};
            cur_int <= (pd_reg == 2'b10);
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      samp   <= '0;
      res    <= '0;
      nb     <= '0;
      divcnt <= '0;
      bz     <= 1'b0;
      dout_r <= 1'b0;
    end else if (start) begin
      samp   <= sample_val;
      res    <= '0;
      nb     <= '0;
      divcnt <= '0;
      bz     <= 1'b0;
      phase  <= (pd_reg == 2'b10) ? PH_ICONV : PH_EWAIT;
    end else begin
      case (phase)
        PH_EWAIT: if (fall) begin
          bz     <= 1'b1;
          dout_r <= 1'b0;
          phase  <= PH_EBUSY;
        end
        PH_EBUSY, PH_SHIFT: if (fall) begin
          bz    <= 1'b0;
          phase <= PH_SHIFT;
          if (nb != CW'(W)) begin
            dout_r <= rd_bit;
            nb     <= nb + 1'b1;
            if (!cur_int && cmp) res <= trial;
          end else begin
            dout_r <= 1'b0;
          end
        end
        PH_ICONV: begin
          if (divcnt == DW'(INT_DIV - 1)) begin
            divcnt <= '0;
            if (cmp) res <= trial;
            if (nb == CW'(W - 1)) begin
              nb    <= '0;
              phase <= PH_SHIFT;
            end else begin
              nb <= nb + 1'b1;
            end
          end else begin
            divcnt <= divcnt + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign dout    = dout_r;
  assign dout_oe = ~cs_n;
  assign busy    = cur_int ? (phase != PH_ICONV) : bz;
  assign busy_oe = ~cs_n | cur_int;
endmodule

module sar_serial_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_n,
  input logic       rise,
  input logic       fall,
  input logic       cur_int,
  input logic       track,
  input logic       busy,
  input logic       dout,
  input logic [2:0] pos_ch,
  input logic       neg_com
);
  p_dout_on_fall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (dout != $past(dout)) |-> $past(fall));

  p_mux_in_acquire_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ((pos_ch != $past(pos_ch)) || (neg_com != $past(neg_com))) |-> track);

  p_track_end_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(track) |-> ($past(rise) || $past(cs_n)));

  p_busy_one_period_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_int && busy && fall) |=> !busy);

  p_busy_rise_on_fall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!cur_int && $rose(busy)) |-> $past(fall));
endmodule

bind sar_serial_seq sar_serial_seq_chk chk_i (
  .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rise(rise), .fall(fall),
  .cur_int(cur_int), .track(track), .busy(busy), .dout(dout),
  .pos_ch(pos_ch), .neg_com(neg_com)
);

// File: tb/sar_serial_seq_tb.sv
module sar_serial_seq_tb_top;
  localparam int H  = 4;
  localparam int ID = 4;

  logic clk = 1'b0, rst_n = 1'b0, dclk = 1'b0, cs_n = 1'b1, din = 1'b0;
  logic [15:0] sample_val = '0;
  logic dout, dout_oe, busy, busy_oe, neg_com, track;
  logic [2:0] pos_ch, neg_ch;
  int nchk = 0, nfail = 0;
  bit done = 0;

  always #10 clk = ~clk;

  sar_serial_seq #(.W(16), .INT_DIV(ID)) dut_i (
    .clk(clk), .rst_n(rst_n), .dclk(dclk), .cs_n(cs_n), .din(din),
    .sample_val(sample_val), .dout(dout), .dout_oe(dout_oe), .busy(busy),
    .busy_oe(busy_oe), .pos_ch(pos_ch), .neg_ch(neg_ch), .neg_com(neg_com),
    .track(track)
  );

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic half(input logic lv);
    dclk = lv;
    repeat (H) @(negedge clk);
  endtask

  task automatic frame(input logic [2:0] a, input logic sgl, input logic [1:0] pd, input int lead);
    logic [7:0] fb;
    fb = {1'b1, a, 1'b0, sgl, pd};
    for (int i = 0; i < lead; i++) begin
      din = 1'b0; half(1'b0); half(1'b1);
      check("R2 leading zero ignored", {15'd0, track}, 16'd0);
    end
    for (int i = 7; i >= 0; i--) begin
      din = fb[i]; half(1'b0); half(1'b1);
      if (i == 3) check("R5 no track before SGL", {15'd0, track}, 16'd0);
      if (i == 2) begin
        check("R5 track after SGL", {15'd0, track}, 16'd1);
        check("R3 R4 positive channel", {13'd0, pos_ch}, 16'(a[1] * 4 + a[0] * 2 + a[2]));
        check("R3 R4 common select", {15'd0, neg_com}, {15'd0, sgl});
        if (!sgl) check("R4 negative channel", {13'd0, neg_ch}, 16'(a[1] * 4 + a[0] * 2 + (1 - a[2])));
      end
    end
    check("R5 hold after PD0", {15'd0, track}, 16'd0);
    din = 1'b0;
  endtask

  task automatic read_ext(input logic [15:0] v, input int extra);
    half(1'b0);
    check("R6 busy pulse high", {15'd0, busy}, 16'd1);
    check("R6 dout low in busy", {15'd0, dout}, 16'd0);
    for (int i = 15; i >= 0; i--) begin
      half(1'b1);
      if (i < 15) check("R1 dout held over rise", {15'd0, dout}, {15'd0, v[i+1]});
      half(1'b0);
      check("R7 R6 result bit", {15'd0, dout}, {15'd0, v[i]});
      if (i == 15) check("R6 busy low after one period", {15'd0, busy}, 16'd0);
    end
    for (int k = 0; k < extra; k++) begin
      half(1'b1); half(1'b0);
      check("R6 zero fill", {15'd0, dout}, 16'd0);
    end
  endtask

  task automatic read_int(input logic [15:0] v);
    for (int i = 15; i >= 0; i--) begin
      half(1'b1); half(1'b0);
      check("R9 internal readout bit", {15'd0, dout}, {15'd0, v[i]});
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nfail++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    finish_run();
  end

  initial begin
    logic [15:0] v;
    repeat (3) @(negedge clk);
    check("R12 reset dout", {15'd0, dout}, 16'd0);
    check("R12 reset busy", {15'd0, busy}, 16'd0);
    check("R12 reset track", {15'd0, track}, 16'd0);
    check("R12 reset mux", {10'd0, pos_ch, neg_ch}, 16'd0);
    check("R12 reset common", {15'd0, neg_com}, 16'd1);
    check("R12 reset enables", {14'd0, dout_oe, busy_oe}, 16'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    cs_n = 1'b0;
    half(1'b0);
    check("R1 dout_oe with select low", {15'd0, dout_oe}, 16'd1);

    for (int c = 0; c < 16; c++) begin
      v = 16'(c * 4369) ^ 16'hA5C3;
      sample_val = v;
      frame(c[2:0], c[3], (c % 3 == 0) ? 2'b00 : ((c % 3 == 1) ? 2'b11 : 2'b01), c % 3);
      sample_val = ~v;
      read_ext(v, (c == 15) ? 2 : 0);
    end

    for (int k = 0; k < 22; k++) begin
      case (k)
        0: v = 16'h0000;  1: v = 16'hFFFF;  2: v = 16'h8000;
        3: v = 16'h7FFF;  4: v = 16'hAAAA;  5: v = 16'h5555;
        default: v = 16'h0001 << (k - 6);
      endcase
      sample_val = v;
      frame(3'b101, 1'b1, 2'b11, 0);
      sample_val = 16'h1234;
      read_ext(v, 1);
    end

    cs_n = 1'b1; half(1'b0);
    check("R1 dout floats with select high", {15'd0, dout_oe}, 16'd0);
    check("R1 busy floats external", {15'd0, busy_oe}, 16'd0);

    cs_n = 1'b0;
    din = 1'b1; half(1'b0); half(1'b1);
    din = 1'b0; half(1'b0); half(1'b1);
    din = 1'b0; half(1'b0); half(1'b1);
    din = 1'b0; half(1'b0); half(1'b1);
    din = 1'b0; half(1'b0); half(1'b1);
    cs_n = 1'b1; half(1'b0);
    check("R11 abort drops track", {15'd0, track}, 16'd0);
    check("R11 abort keeps mux", {13'd0, pos_ch}, 16'd3);
    cs_n = 1'b0;
    v = 16'h3C5A; sample_val = v;
    frame(3'b110, 1'b0, 2'b11, 0);
    read_ext(v, 1);

    v = 16'h0F0F; sample_val = v;
    frame(3'b000, 1'b1, 2'b10, 0);
    read_ext(v, 1);

    v = 16'hC3A1; sample_val = v;
    frame(3'b011, 1'b1, 2'b10, 0);
    half(1'b0);
    check("R8 busy low in internal conversion", {15'd0, busy}, 16'd0);
    cs_n = 1'b1;
    repeat (ID * 6) @(negedge clk);
    check("R8 busy driven with select high", {15'd0, busy_oe}, 16'd1);
    check("R8 busy still low mid conversion", {15'd0, busy}, 16'd0);
    repeat (ID * 16) @(negedge clk);
    check("R8 busy high after conversion", {15'd0, busy}, 16'd1);
    check("R9 dout floats until select", {15'd0, dout_oe}, 16'd0);
    cs_n = 1'b0; half(1'b0);
    check("R9 dout driven after select", {15'd0, dout_oe}, 16'd1);
    read_int(v);

    v = 16'h6E29; sample_val = v;
    frame(3'b111, 1'b0, 2'b11, 0);
    sample_val = 16'h0000;
    half(1'b0);
    check("R10 second internal conversion busy low", {15'd0, busy}, 16'd0);
    repeat (ID * 16 + 4) @(negedge clk);
    check("R8 busy returns high", {15'd0, busy}, 16'd1);
    read_int(v);
    cs_n = 1'b1; half(1'b0);
    check("R8 busy enable held internal", {15'd0, busy_oe}, 16'd1);
    cs_n = 1'b0;

    v = 16'h9B07; sample_val = v;
    frame(3'b010, 1'b1, 2'b01, 0);
    read_ext(v, 1);
    v = 16'h4D72; sample_val = v;
    frame(3'b100, 1'b0, 2'b00, 0);
    read_ext(v, 1);
    cs_n = 1'b1; half(1'b0);
    check("R10 external again floats busy", {15'd0, busy_oe}, 16'd0);

    finish_run();
  end
endmodule